// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, made of a 16-bit segment selector and an offset, into a linear address. It has two modes, chosen by a static mode input. In real mode the selector is a plain segment number: it is shifted left by four bit positions and the low 16 bits of the offset are added to it. In protected mode the selector points into one of two descriptor tables held in memory. The block keeps the descriptor it points to in a single cached copy. The linear address is the cached base plus the full 32-bit offset, and the offset is checked against the descriptor's limit.

Writing the selector while in protected mode starts a descriptor fetch. The fetch is two 32-bit reads over a request/valid memory read port. The selector's bit 2 picks the local or the global table, and bits 15:3 give the entry index, with entries 8 bytes apart. While the fetch runs, the block holds off translation requests and further selector writes. A translation request that is accepted returns its result one cycle later. The result is either a valid linear address or a limit fault. A fetched descriptor whose present bit is clear gives a one-cycle not-present pulse.

Top module: `seg_xlate`

## Requirements
- R1: With `prot_mode` low, an accepted request returns `xl_lin` = `sel*16 + xl_ofs[15:0]`. Offset bits 31:16 are ignored, and the carry out of bit 19 is kept (FFFF:FFFF gives 0x10FFEF, A1F0:04C0 gives 0xA23C0).
- R2: A selector write in protected mode while idle starts a fetch from entry address E = (sel[2] ? `ltab_base` : `gtab_base`) + sel[15:3]*8. The first read is at E and the second at E+4, and `mrd_req` and `mrd_addr` are held until `mrd_valid`.
- R3: Let word 0 (the read at E) be w0 and word 1 be w1. The descriptor decodes as base = {w1[31:24], w1[7:0], w0[15:0]}, limit = {w1[19:16], w0[31:16]}, granularity = w1[23] and present = w1[15]. A protected translation gives `xl_lin` = base + offset modulo 2^32.
- R4: The effective limit is the limit itself when granularity is 0. When granularity is 1 it is {limit, 12'hFFF}. An offset equal to the effective limit translates. An offset above it raises `xl_fault` with `xl_valid` low.
- R5: While a fetch is in progress, `xl_ready` is low. Translation requests and selector writes made in that time are ignored: no result comes out, and after the fetch the first selector's descriptor is the one in use.
- R6: When a fetch ends on a descriptor with present = 0, `np_fault` pulses for exactly one cycle. After that, and also after reset, every protected-mode translation raises `xl_fault` until a present descriptor has been loaded.
- R7: When a translation request and a selector write are accepted in the same cycle, the translation uses the selector and descriptor that were in place before the write.
- R8: After reset, `xl_ready` is high and `xl_valid`, `xl_fault`, `np_fault` and `mrd_req` are low. An accepted request produces its result in the next cycle, and `xl_valid` and `xl_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 selects protected translation, 0 selects real mode |
| gtab_base | input | 32 | Global descriptor table base address |
| ltab_base | input | 32 | Local descriptor table base address |
| sel_wr | input | 1 | Write strobe for the visible selector |
| sel_val | input | 16 | Selector value to write |
| xl_req | input | 1 | Translation request |
| xl_ofs | input | 32 | Offset of the logical address |
| xl_ready | output | 1 | Idle; requests and selector writes are accepted |
| xl_valid | output | 1 | Linear address valid |
| xl_fault | output | 1 | Limit or not-present fault for the request |
| xl_lin | output | 32 | Linear address |
| np_fault | output | 1 | One-cycle pulse: fetched descriptor not present |
| mrd_req | output | 1 | Memory read request |
| mrd_addr | output | 32 | Memory read byte address |
| mrd_valid | input | 1 | Read data valid |
| mrd_data | input | 32 | Read data |

## Verification
A translation request and a selector write can fall in the same cycle. The block must then translate with the old selector and descriptor while the fetch of the new one starts. The bench raises both strobes on one edge, in protected mode and again in real mode. It expects a result computed from the previous selector, and then, once the fetch is done, a result computed from the new one. A second overlap is exercised too: requests and a competing selector write are held high for the whole length of a fetch. The bench expects no output during the fetch and expects the first selector's descriptor to be the one in use afterwards.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int WORD_W    = 32;
   localparam int LIMIT_W   = 20;
   localparam int SEL_W     = 16;
   localparam int TI_BIT    = 2;
   localparam int ENT_SHIFT = 3;
   localparam int G_BIT     = 23;
   localparam int P_BIT     = 15;

   typedef struct packed {
      logic [WORD_W-1:0]  base;
      logic [LIMIT_W-1:0] limit;
      logic               gran;
      logic               present;
   } seg_desc_t;

   typedef enum logic [1:0] {
      LD_IDLE = 2'd0,
      LD_LO   = 2'd1,
      LD_HI   = 2'd2
   } ld_state_e;

   function automatic seg_desc_t desc_unpack(input logic [WORD_W-1:0] w0,
                                             input logic [WORD_W-1:0] w1);
      seg_desc_t d;
      d.base    = {w1[31:24], w1[7:0], w0[15:0]};
      d.limit   = {w1[19:16], w0[31:16]};
      d.gran    = w1[G_BIT];
      d.present = w1[P_BIT];
      return d;
   endfunction

endpackage

// File: rtl/seg_desc_ld.sv
module seg_desc_ld
   import seg_xlate_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] entry_addr,
   output logic              mrd_req,
   output logic [WORD_W-1:0] mrd_addr,
   input  logic              mrd_valid,
   input  logic [WORD_W-1:0] mrd_data,
   output logic              busy,
   output logic              desc_we,
   output seg_desc_t         desc_nxt
);

   localparam logic [WORD_W-1:0] WORD_STEP = WORD_W'(WORD_W / 8);

   ld_state_e         state_q;
   logic [WORD_W-1:0] addr_q;
   logic [WORD_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         addr_q  <= '0;
         lo_q    <= '0;
      end else begin
         case (state_q)
            LD_IDLE: if (start) begin
               addr_q  <= entry_addr;
               state_q <= LD_LO;
            end
            LD_LO: if (mrd_valid) begin
               lo_q    <= mrd_data;
               addr_q  <= addr_q + WORD_STEP;
               state_q <= LD_HI;
            end
            LD_HI: if (mrd_valid) begin
               state_q <= LD_IDLE;
            end
            default: state_q <= LD_IDLE;
         endcase
      end
   end

   assign mrd_req  = (state_q != LD_IDLE);
   assign mrd_addr = addr_q;
   assign busy     = mrd_req;
   assign desc_we  = (state_q == LD_HI) && mrd_valid;
   assign desc_nxt = desc_unpack(lo_q, mrd_data);

endmodule

// File: rtl/seg_lim_chk.sv
module seg_lim_chk
   import seg_xlate_pkg::*;
#(
   parameter int PG_SHIFT = 12
) (
   input  logic [LIMIT_W-1:0] limit,
   input  logic               gran,
   input  logic [WORD_W-1:0]  ofs,
   output logic               over
);

   logic [WORD_W-1:0] eff;

   generate
      if (PG_SHIFT == 0) begin : g_flat
         assign eff = WORD_W'(limit);
      end else begin : g_scaled
         localparam logic [WORD_W-1:0] FILL = WORD_W'((64'd1 << PG_SHIFT) - 64'd1);
         assign eff = gran ? ((WORD_W'(limit) << PG_SHIFT) | FILL) : WORD_W'(limit);
      end
   endgenerate

   assign over = (ofs > eff);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_xlate_pkg::*;
#(
   parameter int SEG_SHIFT  = 4,
   parameter int REAL_OFS_W = 16
) (
   input  logic              prot,
   input  logic [SEL_W-1:0]  sel,
   input  logic [WORD_W-1:0] ofs,
   input  logic [WORD_W-1:0] base,
   output logic [WORD_W-1:0] lin
);

   logic [WORD_W-1:0] real_seg;
   logic [WORD_W-1:0] real_ofs;

   assign real_seg = WORD_W'(sel) << SEG_SHIFT;
   assign real_ofs = WORD_W'(ofs[REAL_OFS_W-1:0]);
   assign lin      = prot ? (base + ofs) : (real_seg + real_ofs);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int PG_SHIFT   = 12,
   parameter int SEG_SHIFT  = 4,
   parameter int REAL_OFS_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_mode,
   input  logic [31:0]       gtab_base,
   input  logic [31:0]       ltab_base,
   input  logic              sel_wr,
   input  logic [15:0]       sel_val,
   input  logic              xl_req,
   input  logic [31:0]       xl_ofs,
   output logic              xl_ready,
   output logic              xl_valid,
   output logic              xl_fault,
   output logic [31:0]       xl_lin,
   output logic              np_fault,
   output logic              mrd_req,
   output logic [31:0]       mrd_addr,
   input  logic              mrd_valid,
   input  logic [31:0]       mrd_data
);

   localparam int IDX_W = SEL_W - ENT_SHIFT;

   generate
      if (PG_SHIFT + LIMIT_W > WORD_W) begin : g_bad_pg
         $error("PG_SHIFT too large for a 32-bit effective limit");
      end
      if (SEG_SHIFT + SEL_W >= WORD_W) begin : g_bad_seg
         $error("SEG_SHIFT too large for the real-mode sum");
      end
      if (REAL_OFS_W < 1 || REAL_OFS_W > WORD_W) begin : g_bad_rofs
         $error("REAL_OFS_W out of range");
      end
   endgenerate

   logic              busy;
   logic              desc_we;
   seg_desc_t         desc_nxt;
   seg_desc_t         desc_q;
   logic [SEL_W-1:0]  sel_q;
   logic [WORD_W-1:0] entry_addr;
   logic [WORD_W-1:0] lin_c;
   logic              over_c;
   logic              fault_c;
   logic              accept;
   logic              load_go;

   assign xl_ready = !busy;
   assign accept   = xl_req && !busy;
   assign load_go  = sel_wr && !busy && prot_mode;

   assign entry_addr = (sel_val[TI_BIT] ? ltab_base : gtab_base)
                     + (WORD_W'(sel_val[SEL_W-1 -: IDX_W]) << ENT_SHIFT);

   seg_desc_ld u_ld (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (load_go),
      .entry_addr (entry_addr),
      .mrd_req    (mrd_req),
      .mrd_addr   (mrd_addr),
      .mrd_valid  (mrd_valid),
      .mrd_data   (mrd_data),
      .busy       (busy),
      .desc_we    (desc_we),
      .desc_nxt   (desc_nxt)
   );

   seg_lim_chk #(.PG_SHIFT(PG_SHIFT)) u_lim (
      .limit (desc_q.limit),
      .gran  (desc_q.gran),
      .ofs   (xl_ofs),
      .over  (over_c)
   );

   seg_addr_gen #(.SEG_SHIFT(SEG_SHIFT), .REAL_OFS_W(REAL_OFS_W)) u_agen (
      .prot (prot_mode),
      .sel  (sel_q),
      .ofs  (xl_ofs),
      .base (desc_q.base),
      .lin  (lin_c)
   );

   assign fault_c = prot_mode && (!desc_q.present || over_c);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= '0;
         desc_q   <= '0;
         np_fault <= 1'b0;
         xl_valid <= 1'b0;
         xl_fault <= 1'b0;
         xl_lin   <= '0;
      end else begin
         if (sel_wr && !busy) sel_q <= sel_val;
         if (desc_we) desc_q <= desc_nxt;
         np_fault <= desc_we && !desc_nxt.present;
         xl_valid <= accept && !fault_c;
         xl_fault <= accept && fault_c;
         xl_lin   <= (accept && !fault_c) ? lin_c : '0;
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        prot_mode,
   input logic        xl_req,
   input logic        xl_ready,
   input logic        xl_valid,
   input logic        xl_fault,
   input logic [31:0] xl_lin,
   input logic        np_fault,
   input logic        mrd_req,
   input logic [31:0] mrd_addr,
   input logic        mrd_valid
);

   // R8: outcome flags are mutually exclusive
   a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(xl_valid && xl_fault));

   // R5: nothing is accepted while a fetch is running
   a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_ready |=> (!xl_valid && !xl_fault));

   // R2: a pending read keeps its request and address
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mrd_req && !mrd_valid) |=> (mrd_req && $stable(mrd_addr)));

   // R1: real-mode results stay below 2^21 and never fault
   a_r1_real_range: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_req && xl_ready && !prot_mode) |=> (xl_valid && (xl_lin >> 21) == 32'd0));

   // R6: the not-present pulse lasts one cycle and carries no translation result
   a_r6_np_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      np_fault |-> (!xl_valid && !xl_fault));

   a_r6_np_once: assert property (@(posedge clk) disable iff (!rst_n)
      np_fault |=> !np_fault);

endmodule

bind seg_xlate seg_xlate_chk u_seg_xlate_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .prot_mode (prot_mode),
   .xl_req    (xl_req),
   .xl_ready  (xl_ready),
   .xl_valid  (xl_valid),
   .xl_fault  (xl_fault),
   .xl_lin    (xl_lin),
   .np_fault  (np_fault),
   .mrd_req   (mrd_req),
   .mrd_addr  (mrd_addr),
   .mrd_valid (mrd_valid)
);

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_mode = 1'b0;
   logic [31:0] gtab_base = 32'h0000_0000;
   logic [31:0] ltab_base = 32'h0000_0200;
   logic        sel_wr = 1'b0;
   logic [15:0] sel_val = '0;
   logic        xl_req = 1'b0;
   logic [31:0] xl_ofs = '0;
   logic        xl_ready, xl_valid, xl_fault, np_fault, mrd_req;
   logic [31:0] xl_lin, mrd_addr;
   logic        mrd_valid = 1'b0;
   logic [31:0] mrd_data = '0;

   logic [31:0] mem [0:255];
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   seg_xlate i_seg_xlate (
      .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
      .gtab_base(gtab_base), .ltab_base(ltab_base),
      .sel_wr(sel_wr), .sel_val(sel_val),
      .xl_req(xl_req), .xl_ofs(xl_ofs),
      .xl_ready(xl_ready), .xl_valid(xl_valid), .xl_fault(xl_fault),
      .xl_lin(xl_lin), .np_fault(np_fault),
      .mrd_req(mrd_req), .mrd_addr(mrd_addr),
      .mrd_valid(mrd_valid), .mrd_data(mrd_data)
   );

   // memory model: one-cycle response, valid drops between reads
   initial begin
      forever begin
         @(posedge clk);
         mrd_valid <= mrd_req && !mrd_valid;
         mrd_data  <= mem[mrd_addr[9:2]];
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] entry_of(input logic [15:0] s);
      return (s[2] ? 32'h200 : 32'h0) + {16'h0, s[15:3], 3'b000};
   endfunction

   function automatic logic [31:0] eff_of(input logic [19:0] lim, input logic g);
      return g ? {lim, 12'hFFF} : {12'h0, lim};
   endfunction

   task automatic put_desc(input logic [15:0] s, input logic [31:0] b,
                           input logic [19:0] lim, input logic g, input logic p);
      logic [31:0] e;
      e = entry_of(s);
      mem[e[9:2]]     = {lim[15:0], b[15:0]};
      mem[e[9:2] + 1] = {b[31:24], g, 3'b000, lim[19:16], p, 7'h00, b[23:16]};
   endtask

   // one request; returns after the result cycle
   task automatic xlate(input logic [31:0] ofs, output logic v, output logic f,
                        output logic [31:0] lin);
      xl_ofs = ofs;
      xl_req = 1'b1;
      @(negedge clk);
      xl_req = 1'b0;
      v = xl_valid; f = xl_fault; lin = xl_lin;
   endtask

   task automatic expect_ok(input string tag, input logic [31:0] ofs, input logic [31:0] exp);
      logic v, f; logic [31:0] lin;
      xlate(ofs, v, f, lin);
      chk({tag, " valid"}, {31'd0, v}, 32'd1);
      chk({tag, " lin"}, lin, exp);
   endtask

   task automatic expect_fault(input string tag, input logic [31:0] ofs);
      logic v, f; logic [31:0] lin;
      xlate(ofs, v, f, lin);
      chk({tag, " fault"}, {30'd0, v, f}, 32'd1);
   endtask

   // selector write in protected mode; optional contention while busy
   task automatic do_load(input logic [15:0] s, input logic exp_np, input logic stall,
                          input logic [15:0] alt);
      logic [31:0] e;
      logic seen_hi;
      int n;
      e = entry_of(s);
      sel_val = s;
      sel_wr = 1'b1;
      @(negedge clk);
      sel_wr = 1'b0;
      chk("R2 first read addr", mrd_addr, e);
      chk("R2 request raised", {31'd0, mrd_req}, 32'd1);
      chk("R5 ready low", {31'd0, xl_ready}, 32'd0);
      seen_hi = 1'b0;
      n = 0;
      if (stall) begin
         xl_req = 1'b1; xl_ofs = 32'h0; sel_wr = 1'b1; sel_val = alt;
      end
      while (!xl_ready && n < 20) begin
         @(negedge clk);
         n++;
         if (mrd_addr == e + 32'd4) seen_hi = 1'b1;
         if (stall) chk("R5 no output while busy", {30'd0, xl_valid, xl_fault}, 32'd0);
      end
      xl_req = 1'b0; sel_wr = 1'b0;
      chk("R2 second read addr", {31'd0, seen_hi}, 32'd1);
      chk("R6 np pulse", {31'd0, np_fault}, {31'd0, exp_np});
      @(negedge clk);
      chk("R6 np one cycle", {31'd0, np_fault}, 32'd0);
   endtask

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 reset ready", {31'd0, xl_ready}, 32'd1);
      chk("R8 reset outs", {28'd0, xl_valid, xl_fault, np_fault, mrd_req}, 32'd0);

      // R6 reset descriptor is not present
      prot_mode = 1'b1;
      expect_fault("R6 after reset", 32'h0);

      // R1 real-mode sweep and known examples
      prot_mode = 1'b0;
      for (int s = 0; s < 16; s++) begin
         logic [15:0] seg;
         seg = 16'(s * 16'h1111) ^ 16'h0F0F;
         sel_val = seg; sel_wr = 1'b1;
         @(negedge clk);
         sel_wr = 1'b0;
         for (int o = 0; o < 6; o++) begin
            logic [31:0] ofs;
            ofs = 32'(o * 32'h2AB3_3331) | ((o == 5) ? 32'h0000_FFFF : 32'h0);
            expect_ok("R1 real sweep", ofs, ({16'h0, seg} << 4) + {16'h0, ofs[15:0]});
         end
      end
      sel_val = 16'hA1F0; sel_wr = 1'b1; @(negedge clk); sel_wr = 1'b0;
      expect_ok("R1 A1F0:04C0", 32'h0000_04C0, 32'h000A_23C0);
      sel_val = 16'h028F; sel_wr = 1'b1; @(negedge clk); sel_wr = 1'b0;
      expect_ok("R1 028F:0030", 32'h0000_0030, 32'h0000_2920);
      sel_val = 16'hFFFF; sel_wr = 1'b1; @(negedge clk); sel_wr = 1'b0;
      chk("R1 no fetch in real mode", {31'd0, mrd_req}, 32'd0);
      expect_ok("R1 carry kept", 32'h1234_FFFF, 32'h0010_FFEF);

      // R3 R4 R6 protected sweep
      prot_mode = 1'b1;
      for (int i = 0; i < 16; i++) begin
         logic [15:0] s; logic [31:0] b; logic [19:0] lim; logic g, p;
         logic [31:0] eff;
         s   = {13'(i + 1), i[0], 2'b01};
         b   = 32'(i) * 32'h1357_2468 + 32'h0000_0123;
         lim = 20'h00010 + 20'(i) * 20'h00111;
         g   = i[1];
         p   = (i != 5);
         if (i == 15) begin lim = 20'hFFFFF; g = 1'b1; b = 32'hFFFF_F000; end
         put_desc(s, b, lim, g, p);
         do_load(s, !p, 1'b0, 16'h0);
         eff = eff_of(lim, g);
         if (!p) begin
            expect_fault("R6 not present", 32'h0);
         end else begin
            expect_ok("R3 base+0", 32'h0, b);
            expect_ok("R4 at limit", eff, b + eff);
            expect_ok("R3 mid", eff >> 1, b + (eff >> 1));
            if (eff != 32'hFFFF_FFFF) expect_fault("R4 above limit", eff + 32'd1);
         end
      end

      // R5 contention during fetch: requests and a second selector write ignored
      put_desc(16'h0050, 32'h0AA0_0000, 20'h00100, 1'b0, 1'b1);
      put_desc(16'h0058, 32'h0BB0_0000, 20'h00100, 1'b0, 1'b1);
      do_load(16'h0050, 1'b0, 1'b1, 16'h0058);
      expect_ok("R5 first selector kept", 32'h10, 32'h0AA0_0010);

      // R7 same-cycle translation and selector write, protected
      sel_val = 16'h0058; sel_wr = 1'b1; xl_ofs = 32'h20; xl_req = 1'b1;
      @(negedge clk);
      sel_wr = 1'b0; xl_req = 1'b0;
      chk("R7 old descriptor used", xl_lin, 32'h0AA0_0020);
      chk("R7 old descriptor valid", {31'd0, xl_valid}, 32'd1);
      for (int n = 0; n < 20 && !xl_ready; n++) @(negedge clk);
      @(negedge clk);
      expect_ok("R7 new descriptor after fetch", 32'h20, 32'h0BB0_0020);

      // R7 same-cycle, real mode
      prot_mode = 1'b0;
      sel_val = 16'h1000; sel_wr = 1'b1; @(negedge clk); sel_wr = 1'b0;
      sel_val = 16'h2000; sel_wr = 1'b1; xl_ofs = 32'h5; xl_req = 1'b1;
      @(negedge clk);
      sel_wr = 1'b0; xl_req = 1'b0;
      chk("R7 real old selector", xl_lin, 32'h0001_0005);
      expect_ok("R7 real new selector", 32'h5, 32'h0002_0005);

      // R8 idle cycle yields no result
      @(negedge clk);
      chk("R8 no request no result", {30'd0, xl_valid, xl_fault}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule